// File: doc/BRIEF.md
# TDM Frame Serial Port

The block moves 2B+D traffic, together with line maintenance and device control octets, between a line transceiver and a host device over a synchronous framed serial link. It runs entirely from one fast system clock. It divides that clock down to a bit clock and a frame sync, and does not generate any second clock domain. Each frame lasts 64 bit periods and carries eight octets in each direction.

On the transmit side, the host presents seven octets on parallel ports. At the first bit of every frame the block copies them into a shadow frame, adds a final all-ones octet, and shifts the frame out most significant bit first. A one-cycle load strobe tells the host that it may now place the octets for the next frame. On the receive side, the block samples the serial input on each falling bit-clock edge and rebuilds the eight received octets. After the 64th bit it raises a one-cycle frame-valid strobe. The received octets then hold until the next frame completes, and a flag reports whether the closing octet was not all ones.

Top module: `tdm_frame_port`

## Requirements
- R1: The bit clock `bclk_o` has a period of 2*HALF_DIV system clock cycles, with a high phase of HALF_DIV cycles and a low phase of HALF_DIV cycles. Each period carries one bit in each direction.
- R2: A frame is 64 bit periods long, so successive frame-sync rising edges are 128*HALF_DIV system cycles apart.
- R3: `fsync_o` rises in the same cycle as the `bclk_o` rising edge that opens bit 0 of a frame. It stays high for exactly one bit period.
- R4: `sdo_o` changes only in a cycle in which `bclk_o` rises.
- R5: The transmitted slots, in time order, are tx_b1, tx_b2, tx_frm, tx_um1, tx_um3, tx_stat, tx_um2 and then the octet 0xFF. Every octet is sent MSB first.
- R6: `sdi_i` is sampled when `bclk_o` falls. The first bit received in a frame becomes bit 7 of `rx_b1_o`. Later bits fill the outputs rx_b1, rx_b2, rx_d, rx_um1, rx_um3, rx_ctl and rx_um2, in that order, each MSB first. The eighth octet is the idle octet.
- R7: `rx_idle_err_o` updates together with the frame-valid strobe. It is 1 when the idle octet of the frame just completed differs from 0xFF, and 0 otherwise.
- R8: The host transmit octets are taken at the start of a frame only. A change during a frame affects the following frame and leaves the frame in progress unchanged.
- R9: The received octet outputs change only in the cycle in which `rx_frame_valid_o` is high, and otherwise hold.
- R10: `rx_frame_valid_o` is high for one cycle per frame. That cycle is the one in which `bclk_o` falls after the 64th bit has been sampled.
- R11: `tx_load_req_o` is a one-cycle pulse in the same cycle as each rising edge of `fsync_o`.
- R12: While reset is held, the outputs are in their reset state: `bclk_o`, `fsync_o`, `rx_frame_valid_o`, `rx_idle_err_o` and `tx_load_req_o` are 0, `sdo_o` is 1, and the received octets are 0. The first rise of `bclk_o` comes HALF_DIV cycles after reset is released and opens frame bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, an even multiple of the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| tx_b1_i | input | 8 | Host octet for the first B channel |
| tx_b2_i | input | 8 | Host octet for the second B channel |
| tx_frm_i | input | 8 | Host framing octet |
| tx_um1_i | input | 8 | Host maintenance octet 1 |
| tx_um3_i | input | 8 | Host maintenance octet 3 |
| tx_stat_i | input | 8 | Host device status octet |
| tx_um2_i | input | 8 | Host maintenance octet 2 |
| tx_load_req_o | output | 1 | Pulse: the shadow frame has been loaded and new host octets may be written |
| bclk_o | output | 1 | Bit clock |
| fsync_o | output | 1 | Frame sync, high during bit 0 |
| sdo_o | output | 1 | Serial data out |
| sdi_i | input | 1 | Serial data in |
| rx_b1_o | output | 8 | Received first B channel octet |
| rx_b2_o | output | 8 | Received second B channel octet |
| rx_d_o | output | 8 | Received D octet |
| rx_um1_o | output | 8 | Received maintenance octet 1 |
| rx_um3_o | output | 8 | Received maintenance octet 3 |
| rx_ctl_o | output | 8 | Received device control octet |
| rx_um2_o | output | 8 | Received maintenance octet 2 |
| rx_frame_valid_o | output | 1 | Pulse: a full receive frame has been captured |
| rx_idle_err_o | output | 1 | The idle octet of the last completed frame was not all ones |

## Verification
The hardest case to reach from the ports is a host write that lands in the middle of a frame being sent. This has to be shown to leave the frame on the wire untouched, while the next frame still carries the new octets. The bench changes every transmit input during bit 1 of every frame, immediately after the load strobe, so each frame it checks runs with the next frame's values already sitting on the host ports. The receive side needs a similar sequence across frames. The bench checks the held octets halfway through the following frame, and it puts a non-ones idle octet into two of the frames to set the error flag. The frame after each of those returns the idle octet to all ones, which checks that the flag clears.

// File: rtl/tdm_frame_pkg.sv
`timescale 1ns/1ps
package tdm_frame_pkg;
  localparam int OCT_W      = 8;
  localparam int NUM_OCT    = 8;
  localparam int FRAME_BITS = OCT_W * NUM_OCT;
  localparam int BIT_IDX_W  = $clog2(FRAME_BITS);
  localparam int BIT_SEL_W  = $clog2(OCT_W);
  localparam int OCT_SEL_W  = $clog2(NUM_OCT);

  typedef logic [OCT_W-1:0] octet_t;
  // index 0 is the first octet on the wire
  typedef octet_t [NUM_OCT-1:0] frame_t;

  typedef enum logic [OCT_SEL_W-1:0] {
    SLOT_B1   = 3'd0,
    SLOT_B2   = 3'd1,
    SLOT_FD   = 3'd2,
    SLOT_M1   = 3'd3,
    SLOT_M3   = 3'd4,
    SLOT_SC   = 3'd5,
    SLOT_M2   = 3'd6,
    SLOT_IDLE = 3'd7
  } slot_e;

  localparam octet_t IDLE_OCTET = '1;
  localparam logic [BIT_IDX_W-1:0] LAST_BIT = BIT_IDX_W'(FRAME_BITS - 1);
endpackage

// File: rtl/tdm_bitclk_gen.sv
`timescale 1ns/1ps
module tdm_bitclk_gen
  import tdm_frame_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  output logic                 bclk,
  output logic                 fsync,
  output logic                 rise_stb,
  output logic                 fall_stb,
  output logic                 frame_start,
  output logic [BIT_IDX_W-1:0] bit_idx,
  output logic [BIT_IDX_W-1:0] next_idx
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_TERM = DIV_W'(HALF_DIV - 1);

  logic [DIV_W-1:0] div_cnt;
  logic             term;

  assign term        = (div_cnt == DIV_TERM);
  assign rise_stb    = term & ~bclk;
  assign fall_stb    = term & bclk;
  assign next_idx    = bit_idx + 1'b1;
  assign frame_start = rise_stb & (next_idx == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt <= '0;
      bclk    <= 1'b0;
      fsync   <= 1'b0;
      bit_idx <= LAST_BIT;
    end else begin
      div_cnt <= term ? '0 : div_cnt + 1'b1;
      if (rise_stb) begin
        bclk    <= 1'b1;
        bit_idx <= next_idx;
        fsync   <= (next_idx == '0);
      end else if (fall_stb) begin
        bclk    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tdm_tx_serializer.sv
`timescale 1ns/1ps
module tdm_tx_serializer
  import tdm_frame_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rise_stb,
  input  logic                 frame_start,
  input  logic [BIT_IDX_W-1:0] next_idx,
  input  frame_t               host_frame,
  output logic                 sdo,
  output logic                 load_req
);
  frame_t                shadow;
  logic [OCT_SEL_W-1:0]  oct_sel;
  logic [BIT_SEL_W-1:0]  bit_sel;

  assign oct_sel = next_idx[BIT_IDX_W-1:BIT_SEL_W];
  assign bit_sel = ~next_idx[BIT_SEL_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow   <= '1;
      sdo      <= 1'b1;
      load_req <= 1'b0;
    end else begin
      load_req <= frame_start;
      if (frame_start) begin
        shadow <= host_frame;
        sdo    <= host_frame[0][OCT_W-1];
      end else if (rise_stb) begin
        sdo    <= shadow[oct_sel][bit_sel];
      end
    end
  end
endmodule

// File: rtl/tdm_rx_deserializer.sv
`timescale 1ns/1ps
module tdm_rx_deserializer
  import tdm_frame_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fall_stb,
  input  logic [BIT_IDX_W-1:0] bit_idx,
  input  logic                 sdi,
  output frame_t               rx_frame,
  output logic                 frame_valid,
  output logic                 idle_err
);
  logic [FRAME_BITS-2:0] shift_q;
  logic [FRAME_BITS-1:0] word;
  frame_t                word_frame;
  logic                  last_bit;

  assign word     = {shift_q, sdi};
  assign last_bit = fall_stb & (bit_idx == LAST_BIT);

  always_comb begin
    for (int k = 0; k < NUM_OCT; k++) begin
      word_frame[k] = word[FRAME_BITS-1-k*OCT_W -: OCT_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q     <= '0;
      rx_frame    <= '0;
      frame_valid <= 1'b0;
      idle_err    <= 1'b0;
    end else begin
      frame_valid <= last_bit;
      if (fall_stb) begin
        shift_q <= word[FRAME_BITS-2:0];
      end
      if (last_bit) begin
        rx_frame <= word_frame;
        idle_err <= (word_frame[SLOT_IDLE] != IDLE_OCTET);
      end
    end
  end
endmodule

// File: rtl/tdm_frame_port.sv
`timescale 1ns/1ps
module tdm_frame_port
  import tdm_frame_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] tx_b1_i,
  input  logic [7:0] tx_b2_i,
  input  logic [7:0] tx_frm_i,
  input  logic [7:0] tx_um1_i,
  input  logic [7:0] tx_um3_i,
  input  logic [7:0] tx_stat_i,
  input  logic [7:0] tx_um2_i,
  output logic       tx_load_req_o,
  output logic       bclk_o,
  output logic       fsync_o,
  output logic       sdo_o,
  input  logic       sdi_i,
  output logic [7:0] rx_b1_o,
  output logic [7:0] rx_b2_o,
  output logic [7:0] rx_d_o,
  output logic [7:0] rx_um1_o,
  output logic [7:0] rx_um3_o,
  output logic [7:0] rx_ctl_o,
  output logic [7:0] rx_um2_o,
  output logic       rx_frame_valid_o,
  output logic       rx_idle_err_o
);
  logic                 rise_stb, fall_stb, frame_start;
  logic [BIT_IDX_W-1:0] bit_idx, next_idx;
  frame_t               host_frame, rx_frame;

  always_comb begin
    host_frame            = '0;
    host_frame[SLOT_B1]   = tx_b1_i;
    host_frame[SLOT_B2]   = tx_b2_i;
    host_frame[SLOT_FD]   = tx_frm_i;
    host_frame[SLOT_M1]   = tx_um1_i;
    host_frame[SLOT_M3]   = tx_um3_i;
    host_frame[SLOT_SC]   = tx_stat_i;
    host_frame[SLOT_M2]   = tx_um2_i;
    host_frame[SLOT_IDLE] = IDLE_OCTET;
  end

  tdm_bitclk_gen #(.HALF_DIV(HALF_DIV)) u_clkgen (
    .clk         (clk),
    .rst         (rst),
    .bclk        (bclk_o),
    .fsync       (fsync_o),
    .rise_stb    (rise_stb),
    .fall_stb    (fall_stb),
    .frame_start (frame_start),
    .bit_idx     (bit_idx),
    .next_idx    (next_idx)
  );

  tdm_tx_serializer u_tx (
    .clk         (clk),
    .rst         (rst),
    .rise_stb    (rise_stb),
    .frame_start (frame_start),
    .next_idx    (next_idx),
    .host_frame  (host_frame),
    .sdo         (sdo_o),
    .load_req    (tx_load_req_o)
  );

  tdm_rx_deserializer u_rx (
    .clk         (clk),
    .rst         (rst),
    .fall_stb    (fall_stb),
    .bit_idx     (bit_idx),
    .sdi         (sdi_i),
    .rx_frame    (rx_frame),
    .frame_valid (rx_frame_valid_o),
    .idle_err    (rx_idle_err_o)
  );

  assign rx_b1_o  = rx_frame[SLOT_B1];
  assign rx_b2_o  = rx_frame[SLOT_B2];
  assign rx_d_o   = rx_frame[SLOT_FD];
  assign rx_um1_o = rx_frame[SLOT_M1];
  assign rx_um3_o = rx_frame[SLOT_M3];
  assign rx_ctl_o = rx_frame[SLOT_SC];
  assign rx_um2_o = rx_frame[SLOT_M2];
endmodule

// File: rtl/tdm_frame_port_chk.sv
`timescale 1ns/1ps
module tdm_frame_port_chk #(
  parameter int HALF_DIV = 2
) (
  input logic        clk,
  input logic        rst,
  input logic        bclk_o,
  input logic        fsync_o,
  input logic        sdo_o,
  input logic        tx_load_req_o,
  input logic        rx_frame_valid_o,
  input logic [55:0] rx_all
);
  logic bclk_d;
  int   since_tog;

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_d    <= 1'b0;
      since_tog <= 0;
    end else begin
      bclk_d    <= bclk_o;
      since_tog <= (bclk_o != bclk_d) ? 1 : since_tog + 1;
    end
  end

  AST_BCLK_HALF_PERIOD: assert property (@(posedge clk) disable iff (rst)
    (bclk_o != bclk_d) |-> (since_tog == HALF_DIV)); // R1

  AST_FSYNC_ON_BCLK_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(fsync_o) |-> $rose(bclk_o)); // R3

  AST_SDO_MOVES_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdo_o) |-> $rose(bclk_o)); // R4

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rx_frame_valid_o |-> $stable(rx_all)); // R9

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rx_frame_valid_o |=> !rx_frame_valid_o); // R10

  AST_VALID_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    rx_frame_valid_o |-> $fell(bclk_o)); // R10

  AST_LOAD_WITH_FSYNC: assert property (@(posedge clk) disable iff (rst)
    tx_load_req_o |-> $rose(fsync_o)); // R11

  AST_FSYNC_GIVES_LOAD: assert property (@(posedge clk) disable iff (rst)
    $rose(fsync_o) |-> tx_load_req_o); // R11
endmodule

bind tdm_frame_port tdm_frame_port_chk #(.HALF_DIV(HALF_DIV)) u_chk (
  .clk              (clk),
  .rst              (rst),
  .bclk_o           (bclk_o),
  .fsync_o          (fsync_o),
  .sdo_o            (sdo_o),
  .tx_load_req_o    (tx_load_req_o),
  .rx_frame_valid_o (rx_frame_valid_o),
  .rx_all           ({rx_b1_o, rx_b2_o, rx_d_o, rx_um1_o, rx_um3_o, rx_ctl_o, rx_um2_o})
);

// File: tb/sim_tdm_frame_port.sv
`timescale 1ns/1ps
module sim_tdm_frame_port;
  localparam int HALF = 2;
  localparam int NF   = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] tx_b1, tx_b2, tx_frm, tx_um1, tx_um3, tx_stat, tx_um2;
  logic       sdi = 1'b1;
  logic       tx_load_req, bclk, fsync, sdo, valid, idle_err;
  logic [7:0] rx_b1, rx_b2, rx_d, rx_um1, rx_um3, rx_ctl, rx_um2;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int n_valid = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst && valid) n_valid <= n_valid + 1;
  end

  tdm_frame_port #(.HALF_DIV(HALF)) u0 (
    .clk(clk), .rst(rst),
    .tx_b1_i(tx_b1), .tx_b2_i(tx_b2), .tx_frm_i(tx_frm), .tx_um1_i(tx_um1),
    .tx_um3_i(tx_um3), .tx_stat_i(tx_stat), .tx_um2_i(tx_um2),
    .tx_load_req_o(tx_load_req), .bclk_o(bclk), .fsync_o(fsync),
    .sdo_o(sdo), .sdi_i(sdi),
    .rx_b1_o(rx_b1), .rx_b2_o(rx_b2), .rx_d_o(rx_d), .rx_um1_o(rx_um1),
    .rx_um3_o(rx_um3), .rx_ctl_o(rx_ctl), .rx_um2_o(rx_um2),
    .rx_frame_valid_o(valid), .rx_idle_err_o(idle_err)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] tx_oct(input int f, input int k);
    if (k == 7) return 8'hFF;
    if (f == 1) return 8'h00;
    if (f == 3) return 8'hFF;
    return 8'((f * 37 + k * 53 + 11) & 255);
  endfunction

  function automatic logic [7:0] rx_oct(input int f, input int k);
    if (k == 7) return (f == 2) ? 8'h7F : (f == 4) ? 8'hFE : 8'hFF;
    if (f == 3) return 8'h00;
    return 8'((f * 91 + k * 29 + 5) & 255);
  endfunction

  function automatic logic [63:0] frame_word(input int f, input bit is_tx);
    logic [63:0] w;
    for (int k = 0; k < 8; k++) w[63-8*k -: 8] = is_tx ? tx_oct(f, k) : rx_oct(f, k);
    return w;
  endfunction

  task automatic set_tx(input int f);
    tx_b1 = tx_oct(f, 0); tx_b2 = tx_oct(f, 1); tx_frm = tx_oct(f, 2);
    tx_um1 = tx_oct(f, 3); tx_um3 = tx_oct(f, 4); tx_stat = tx_oct(f, 5);
    tx_um2 = tx_oct(f, 6);
  endtask

  function automatic logic [55:0] rx_now();
    return {rx_b1, rx_b2, rx_d, rx_um1, rx_um3, rx_ctl, rx_um2};
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int rel_cyc;
    int t_frame;
    int t_b0;
    logic [63:0] sent;
    logic [63:0] rxw;
    set_tx(0);
    repeat (4) @(posedge clk);
    #1;
    // R12 reset state
    chk("R12", "bclk in reset", 64'(bclk), 64'd0);
    chk("R12", "fsync in reset", 64'(fsync), 64'd0);
    chk("R12", "sdo in reset", 64'(sdo), 64'd1);
    chk("R12", "flags in reset", {61'd0, valid, idle_err, tx_load_req}, 64'd0);
    chk("R12", "rx octets in reset", 64'(rx_now()), 64'd0);
    rst = 1'b0;
    rel_cyc = cyc;
    t_frame = 0;
    t_b0 = 0;
    for (int f = 0; f < NF; f++) begin
      rxw = frame_word(f, 1'b0);
      for (int b = 0; b < 64; b++) begin
        @(posedge bclk);
        #1;
        if (b == 0) begin
          chk("R3", "fsync at bit 0", 64'(fsync), 64'd1);
          chk("R11", "load request at frame start", 64'(tx_load_req), 64'd1);
          if (f == 0) chk("R12", "first bclk rise delay", 64'(cyc - rel_cyc), 64'(HALF));
          else chk("R2", "frame period cycles", 64'(cyc - t_frame), 64'(128 * HALF));
          t_frame = cyc;
          t_b0 = cyc;
        end
        if (b == 1) begin
          chk("R3", "fsync low at bit 1", 64'(fsync), 64'd0);
          chk("R11", "load request one cycle", 64'(tx_load_req), 64'd0);
          chk("R1", "bit period cycles", 64'(cyc - t_b0), 64'(2 * HALF));
          set_tx(f + 1); // R8 host write in the middle of a frame
        end
        if (b == 32 && f > 0)
          chk("R9", "rx octets held mid-frame", 64'(rx_now()), 64'(frame_word(f - 1, 1'b0) >> 8));
        sdi = rxw[63 - b];
        @(negedge bclk);
        #1;
        sent[63 - b] = sdo;
        if (b == 63) begin
          chk("R10", "frame valid after last bit", 64'(valid), 64'd1);
          chk("R6", "received octets", 64'(rx_now()), 64'(rxw >> 8));
          chk("R7", "idle octet error", 64'(idle_err), 64'(rxw[7:0] != 8'hFF));
          @(posedge clk);
          #1;
          chk("R10", "frame valid drops", 64'(valid), 64'd0);
        end
      end
      chk("R5", "transmitted frame order", sent, frame_word(f, 1'b1)); // R8 unaffected by mid-frame write
    end
    chk("R10", "valid pulses per frame", 64'(n_valid), 64'(NF));
    summary();
    $finish;
  end
endmodule